// File: doc/BRIEF.md
# Power-Management Function I/O Window Decoder

This block holds the configuration state of a PCI function that owns two relocatable I/O ranges. One range is 128 bytes long and holds the power-management registers. The other is 16 bytes long and holds a system-management bus controller. Software programs each base address and its enable bit through dword-addressed configuration writes with byte enables. The block then reports, combinationally, whether the current I/O bus address falls inside either range.

The base registers keep only their aligned upper bits, and bit 0 always reads back as 1. Each enable bit lives in its own configuration byte. Configuration dwords that are not modelled read as zero, and writes to them are dropped.

A separate path forms a level-sensitive system control interrupt. It takes 16-bit event status and event enable words and raises the interrupt when any of four event classes has both its status bit and its enable bit set.

Top module: `pmfn_window_decoder`

## Requirements
- R1: The power-management base dword (dword index 0x12, byte offset 0x48) stores only bits 15:7. Bits 31:16 and 6:1 read 0, so writing 0xFFFFFFFF with all byte enables reads back 0x0000FF81.
- R2: The bus-controller base dword (dword index 0x24, byte offset 0x90) stores only bits 15:4. Bits 31:16 and 3:1 read 0, so writing 0xFFFFFFFF reads back 0x0000FFF1.
- R3: Bit 0 of both base dwords reads 1 at all times, after reset and after any write.
- R4: The power-management range is enabled by bit 7 of configuration byte 0x41, which is lane 1 (bits 15:8) of dword index 0x10. pm_hit is 1 exactly when that bit is set and io_addr[15:7] equals base bits 15:7.
- R5: The bus-controller range is enabled by bit 0 of configuration byte 0xD2, which is lane 2 (bits 23:16) of dword index 0x34. smb_hit is 1 exactly when that bit is set and io_addr[15:4] equals base bits 15:4.
- R6: Byte 0xD2 keeps only its low four bits: a write of 0xFF to it reads back 0x0F, which appears as 0x000F0000 in dword 0x34.
- R7: After reset, both base dwords read 0x00000001, dwords 0x10 and 0x34 read 0, and neither hit output is set.
- R8: sci_irq is 1 exactly when pm1_sts AND pm1_en is nonzero in at least one of these bits: bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock). Other bits have no effect.
- R9: A configuration write changes only the byte lanes whose cfg_be bit is 1. Bit n of cfg_be selects data bits 8n+7:8n.
- R10: Every other configuration dword reads 0, and writes to it change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for the dword at cfg_dw (combinational) |
| io_addr | input | 16 | I/O bus address to decode |
| pm_hit | output | 1 | io_addr is inside the enabled power-management range |
| smb_hit | output | 1 | io_addr is inside the enabled bus-controller range |
| pm1_sts | input | 16 | Event status bits |
| pm1_en | input | 16 | Event enable bits |
| sci_irq | output | 1 | System control interrupt level |

## Verification
The decode is probed on the last address below each range, the first and last addresses inside it, and the first address above it. Each probe is made with the range enabled, disabled and never enabled, so an off-by-one comparison width is told apart from a missing enable gate.

Base writes use all-ones data, partial byte enables and unaligned values. These separate the masking of low bits, the forcing of bit 0 and the lane selection.

The interrupt is driven with one enable bit at a time, with every non-event bit enabled, and with status cleared. This isolates each of the four event classes from the rest.

// File: rtl/pmfn_pkg.sv
package pmfn_pkg;
  // Dword indices of the modelled configuration locations
  localparam logic [5:0] PM_BASE_DW  = 6'h12;  // bytes 0x48..0x4B
  localparam logic [5:0] SMB_BASE_DW = 6'h24;  // bytes 0x90..0x93
  localparam logic [5:0] PM_CTL_DW   = 6'h10;  // holds byte 0x41 in lane 1
  localparam logic [5:0] SMB_CTL_DW  = 6'h34;  // holds byte 0xD2 in lane 2
  localparam int PM_CTL_LANE  = 1;
  localparam int SMB_CTL_LANE = 2;
  localparam int PM_EN_BIT    = 7;
  localparam int SMB_EN_BIT   = 0;
  // Event classes that can raise the interrupt: timer, global lock, power button, RTC
  localparam logic [15:0] SCI_EVT_MASK = 16'h0521;
endpackage

// File: rtl/pmfn_cfg_regs.sv
module pmfn_cfg_regs
  import pmfn_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PM_ALIGN  = 7,
  parameter int SMB_ALIGN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [ADDR_W-1:0] pm_base,
  output logic              pm_on,
  output logic [ADDR_W-1:0] smb_base,
  output logic              smb_on
);
  localparam int PM_CTL_LSB  = PM_CTL_LANE * 8;
  localparam int SMB_CTL_LSB = SMB_CTL_LANE * 8;

  logic [ADDR_W-1:PM_ALIGN]  pm_hi_q,  pm_hi_d;
  logic [ADDR_W-1:SMB_ALIGN] smb_hi_q, smb_hi_d;
  logic [7:0]                pm_ctl_q;
  logic [3:0]                smb_ctl_q;
  logic pm_base_wr, smb_base_wr, pm_ctl_wr, smb_ctl_wr;

  // Write decode
  always_comb begin
    pm_base_wr  = cfg_we && (cfg_dw == PM_BASE_DW);
    smb_base_wr = cfg_we && (cfg_dw == SMB_BASE_DW);
    pm_ctl_wr   = cfg_we && (cfg_dw == PM_CTL_DW)  && cfg_be[PM_CTL_LANE];
    smb_ctl_wr  = cfg_we && (cfg_dw == SMB_CTL_DW) && cfg_be[SMB_CTL_LANE];
  end

  // Next state: only enabled lanes of the writable field are replaced
  always_comb begin
    pm_hi_d = pm_hi_q;
    for (int b = PM_ALIGN; b < ADDR_W; b++)
      if (cfg_be[b >> 3]) pm_hi_d[b] = cfg_wdata[b];
    smb_hi_d = smb_hi_q;
    for (int b = SMB_ALIGN; b < ADDR_W; b++)
      if (cfg_be[b >> 3]) smb_hi_d[b] = cfg_wdata[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_hi_q   <= '0;
      smb_hi_q  <= '0;
      pm_ctl_q  <= '0;
      smb_ctl_q <= '0;
    end else begin
      if (pm_base_wr)  pm_hi_q   <= pm_hi_d;
      if (smb_base_wr) smb_hi_q  <= smb_hi_d;
      if (pm_ctl_wr)   pm_ctl_q  <= cfg_wdata[PM_CTL_LSB +: 8];
      if (smb_ctl_wr)  smb_ctl_q <= cfg_wdata[SMB_CTL_LSB +: 4];
    end
  end

  // Readback
  always_comb begin
    cfg_rdata = '0;
    case (cfg_dw)
      PM_BASE_DW: begin
        cfg_rdata[ADDR_W-1:PM_ALIGN] = pm_hi_q;
        cfg_rdata[0] = 1'b1;
      end
      SMB_BASE_DW: begin
        cfg_rdata[ADDR_W-1:SMB_ALIGN] = smb_hi_q;
        cfg_rdata[0] = 1'b1;
      end
      PM_CTL_DW:  cfg_rdata[PM_CTL_LSB +: 8]  = pm_ctl_q;
      SMB_CTL_DW: cfg_rdata[SMB_CTL_LSB +: 4] = smb_ctl_q;
      default:    cfg_rdata = '0;
    endcase
  end

  always_comb begin
    pm_base  = '0;
    pm_base[ADDR_W-1:PM_ALIGN] = pm_hi_q;
    smb_base = '0;
    smb_base[ADDR_W-1:SMB_ALIGN] = smb_hi_q;
    pm_on  = pm_ctl_q[PM_EN_BIT];
    smb_on = smb_ctl_q[SMB_EN_BIT];
  end

  // A write with lane 1 disabled leaves the upper base byte alone
  assert_pm_lane_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw == PM_BASE_DW && !cfg_be[1]) |=> $stable(pm_hi_q[ADDR_W-1:8]));

  // Byte 0xD2 takes the low nibble of the written lane
  assert_smb_ctl_nibble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    smb_ctl_wr |=> (smb_ctl_q == $past(cfg_wdata[SMB_CTL_LSB +: 4])));

  // A write to an unmodelled dword leaves both bases alone
  assert_other_dw_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw != PM_BASE_DW && cfg_dw != SMB_BASE_DW)
      |=> ($stable(pm_hi_q) && $stable(smb_hi_q)));
endmodule

// File: rtl/pmfn_win_match.sv
module pmfn_win_match #(
  parameter int ADDR_W    = 16,
  parameter int WIN_BYTES = 128
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              on,
  output logic              hit
);
  localparam int ALIGN = $clog2(WIN_BYTES);

  always_comb begin
    hit = on && (io_addr[ADDR_W-1:ALIGN] == base[ADDR_W-1:ALIGN]);
  end
endmodule

// File: rtl/pmfn_sci_combine.sv
module pmfn_sci_combine #(
  parameter int          EVT_W    = 16,
  parameter logic [15:0] EVT_MASK = 16'h0521
) (
  input  logic [EVT_W-1:0] sts,
  input  logic [EVT_W-1:0] en,
  output logic             irq
);
  logic [EVT_W-1:0] term;

  for (genvar g = 0; g < EVT_W; g++) begin : g_evt
    if (EVT_MASK[g]) begin : g_used
      assign term[g] = sts[g] & en[g];
    end else begin : g_unused
      assign term[g] = 1'b0;
    end
  end

  assign irq = |term;
endmodule

// File: rtl/pmfn_window_decoder.sv
module pmfn_window_decoder
  import pmfn_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PM_BYTES  = 128,
  parameter int SMB_BYTES = 16,
  parameter int EVT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_dw,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              pm_hit,
  output logic              smb_hit,
  input  logic [EVT_W-1:0]  pm1_sts,
  input  logic [EVT_W-1:0]  pm1_en,
  output logic              sci_irq
);
  localparam int PM_ALIGN  = $clog2(PM_BYTES);
  localparam int SMB_ALIGN = $clog2(SMB_BYTES);

  logic [ADDR_W-1:0] pm_base, smb_base;
  logic              pm_on, smb_on;

  pmfn_cfg_regs #(.ADDR_W(ADDR_W), .PM_ALIGN(PM_ALIGN), .SMB_ALIGN(SMB_ALIGN)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .pm_on(pm_on), .smb_base(smb_base), .smb_on(smb_on)
  );

  pmfn_win_match #(.ADDR_W(ADDR_W), .WIN_BYTES(PM_BYTES)) u_pm_win (
    .io_addr(io_addr), .base(pm_base), .on(pm_on), .hit(pm_hit)
  );

  pmfn_win_match #(.ADDR_W(ADDR_W), .WIN_BYTES(SMB_BYTES)) u_smb_win (
    .io_addr(io_addr), .base(smb_base), .on(smb_on), .hit(smb_hit)
  );

  pmfn_sci_combine #(.EVT_W(EVT_W), .EVT_MASK(SCI_EVT_MASK)) u_sci (
    .sts(pm1_sts), .en(pm1_en), .irq(sci_irq)
  );

  assert_pm_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == PM_BASE_DW) |-> cfg_rdata[0]);
  assert_smb_bit0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw == SMB_BASE_DW) |-> cfg_rdata[0]);
  assert_pm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_on |-> !pm_hit);
  assert_smb_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !smb_on |-> !smb_hit);
  assert_sci_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm1_en == '0) |-> !sci_irq);
endmodule

// File: tb/sim_pmfn_window_decoder.sv
module sim_pmfn_window_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [15:0] pm1_sts = '0;
  logic [15:0] pm1_en = '0;
  logic        sci_irq;

  pmfn_window_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .pm_hit(pm_hit), .smb_hit(smb_hit), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
    .sci_irq(sci_irq)
  );

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [31:0] m_pm  = 32'h1;
  logic [31:0] m_smb = 32'h1;
  logic [7:0]  m_b41 = 8'h0;
  logic [7:0]  m_bd2 = 8'h0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] old_v, logic [31:0] new_v, logic [3:0] be);
    logic [31:0] r = old_v;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] dw);
    case (dw)
      6'h12:   return m_pm;
      6'h24:   return m_smb;
      6'h10:   return {16'h0, m_b41, 8'h0};
      6'h34:   return {8'h0, m_bd2, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [5:0] dw);
    case (dw)
      6'h12:   return "R1";
      6'h24:   return "R2";
      6'h10:   return "R4";
      6'h34:   return "R6";
      default: return "R10";
    endcase
  endfunction

  // Compare every clock, away from the edges
  always begin
    @(negedge clk);
    #4;
    if (live && !done) begin
      check(rd_tag(cfg_dw), cfg_rdata, exp_rd(cfg_dw));
      check("R4", {31'b0, pm_hit},
            {31'b0, m_b41[7] && ((io_addr & 16'hFF80) == (m_pm[15:0] & 16'hFF80))});
      check("R5", {31'b0, smb_hit},
            {31'b0, m_bd2[0] && ((io_addr & 16'hFFF0) == (m_smb[15:0] & 16'hFFF0))});
      check("R8", {31'b0, sci_irq}, {31'b0, |(pm1_sts & pm1_en & 16'h0521)});
    end
  end

  task automatic wr(logic [5:0] dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(posedge clk);
    case (dw)
      6'h12: m_pm  = (merge(m_pm,  d, be) & 32'h0000FF80) | 32'h1;
      6'h24: m_smb = (merge(m_smb, d, be) & 32'h0000FFF0) | 32'h1;
      6'h10: if (be[1]) m_b41 = d[15:8];
      6'h34: if (be[2]) m_bd2 = {4'h0, d[19:16]};
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] dw, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_dw = dw;
    #5;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic probe(logic [15:0] a, logic e_pm, logic e_smb, string tag);
    @(negedge clk);
    io_addr = a;
    #5;
    check(tag, {30'b0, pm_hit, smb_hit}, {30'b0, e_pm, e_smb});
  endtask

  task automatic sci(logic [15:0] s, logic [15:0] e, logic exp);
    @(negedge clk);
    pm1_sts = s; pm1_en = e;
    #5;
    check("R8", {31'b0, sci_irq}, {31'b0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    // R7 reset state
    rd(6'h12, 32'h1, "R7");
    rd(6'h24, 32'h1, "R7");
    rd(6'h10, 32'h0, "R7");
    rd(6'h34, 32'h0, "R7");
    probe(16'h0000, 1'b0, 1'b0, "R7");
    // R1/R2 all-ones masking, R3 forced bit 0
    wr(6'h12, 4'hF, 32'hFFFF_FFFF);
    rd(6'h12, 32'h0000_FF81, "R1");
    wr(6'h24, 4'hF, 32'hFFFF_FFFF);
    rd(6'h24, 32'h0000_FFF1, "R2");
    // R9 byte enables
    wr(6'h12, 4'b0001, 32'h0000_0000);
    rd(6'h12, 32'h0000_FF01, "R9");
    wr(6'h12, 4'b0011, 32'h0000_1200);
    rd(6'h12, 32'h0000_1201, "R1");
    wr(6'h12, 4'b1100, 32'hFFFF_FFFF);
    rd(6'h12, 32'h0000_1201, "R9");
    wr(6'h24, 4'hF, 32'h0000_501E);
    rd(6'h24, 32'h0000_5011, "R2");
    check("R3", {31'b0, cfg_rdata[0]}, 32'h1);
    // R4 power-management range
    probe(16'h1200, 1'b0, 1'b0, "R4");
    wr(6'h10, 4'b0010, 32'h0000_8000);
    rd(6'h10, 32'h0000_8000, "R4");
    probe(16'h11FF, 1'b0, 1'b0, "R4");
    probe(16'h1200, 1'b1, 1'b0, "R4");
    probe(16'h127F, 1'b1, 1'b0, "R4");
    probe(16'h1280, 1'b0, 1'b0, "R4");
    // R5/R6 bus-controller range
    probe(16'h5010, 1'b0, 1'b0, "R5");
    wr(6'h34, 4'b0100, 32'h00FF_0000);
    rd(6'h34, 32'h000F_0000, "R6");
    probe(16'h500F, 1'b0, 1'b0, "R5");
    probe(16'h5010, 1'b0, 1'b1, "R5");
    probe(16'h501F, 1'b0, 1'b1, "R5");
    probe(16'h5020, 1'b0, 1'b0, "R5");
    wr(6'h34, 4'b0100, 32'h00FE_0000);
    rd(6'h34, 32'h000E_0000, "R6");
    probe(16'h5010, 1'b0, 1'b0, "R5");
    // R9 lane 1 of dword 0x10 not enabled: enable stays
    wr(6'h10, 4'b1101, 32'h0000_0000);
    probe(16'h1240, 1'b1, 1'b0, "R9");
    wr(6'h10, 4'b0010, 32'h0000_0000);
    probe(16'h1240, 1'b0, 1'b0, "R4");
    // R10 unmodelled dwords
    wr(6'h11, 4'hF, 32'hFFFF_FFFF);
    rd(6'h11, 32'h0, "R10");
    rd(6'h12, 32'h0000_1201, "R10");
    wr(6'h35, 4'hF, 32'hFFFF_FFFF);
    rd(6'h34, 32'h000E_0000, "R10");
    // R8 interrupt combine
    sci(16'hFFFF, 16'h0000, 1'b0);
    foreach (SCI_BITS[i]) begin
      sci(16'hFFFF, 16'h1 << SCI_BITS[i], 1'b1);
      sci(16'h0000, 16'h1 << SCI_BITS[i], 1'b0);
      sci(16'h1 << SCI_BITS[i], 16'hFFFF, 1'b1);
    end
    sci(16'hFFFF, 16'hFADE, 1'b0);
    sci(16'h0000, 16'hFFFF, 1'b0);
    repeat (2) @(negedge clk);
    finish_run();
  end

  localparam int SCI_BITS [4] = '{0, 5, 8, 10};
endmodule